// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block moves outgoing frames from system memory onto a byte stream. Software builds a ring of descriptors. Each descriptor names one buffer segment, and a frame may span several descriptors. Software then gives the engine the address of the ring head and pulses a start input. Over a single word-wide memory master port, the engine fetches each descriptor and copies that segment's bytes into an internal frame store. It then hands the descriptor back to software by rewriting the descriptor's first word. When the last segment of a frame has been gathered, the complete frame is streamed out with a valid/ready handshake.

Before any segment is taken, the engine searches forward from the head for the first descriptor that it owns. After that point, the first descriptor it does not own ends the walk. A next pointer of zero also ends the walk. If a segment would push the frame beyond the store's capacity, the engine flags a length error in that descriptor, drops the partial frame and stops. A walk that sends at least one frame raises a sticky transmit-complete flag and clears the run flag that the start pulse set.

Top module: `tx_gather`

## Requirements
- R1: After reset, the engine requests no memory access, presents no frame data, and holds `tx_irq`, `dma_run`, `busy` and `done` low.
- R2: A descriptor is four words at byte offsets +0 (status), +4 (control), +8 (buffer address) and +12 (next pointer). The segment byte count is control bits 10:0. Buffer addresses are word aligned, and the bytes of each word are taken lowest byte first.
- R3: Status bit 31 set means the engine owns the descriptor. While no owned descriptor has yet been found, non-owned descriptors are skipped by following their next pointer. If a next pointer of zero or equal to the head is reached first, the walk ends with nothing sent, `tx_irq` low and `dma_run` still high.
- R4: Once an owned descriptor has been taken, the first non-owned descriptor ends the walk, and descriptors after it are left untouched.
- R5: Segments are concatenated in ring order until a descriptor with control bit 30 set. The whole frame is then streamed, with `out_last` high on its final byte only.
- R6: After a segment has been copied, the status word is written back with bit 31 cleared and every other bit unchanged. This happens before the next pointer is followed.
- R7: The frame store holds 2048 bytes, and a frame of exactly 2048 bytes is sent. A segment that would take the frame past 2048 bytes gets status written back with bit 14 set and bit 31 still set. The partial frame is discarded and the walk ends.
- R8: A walk that sent at least one frame sets `tx_irq` and clears `dma_run` one cycle after `done`. A start pulse clears `tx_irq` and sets `dma_run`.
- R9: A taken descriptor whose next pointer is zero ends the walk after its write-back.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a walk when the engine is idle |
| list_base | input | 32 | Byte address of the ring head |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_last | output | 1 | Final byte of the frame |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse as the walk ends |
| dma_run | output | 1 | Run flag: set by start, cleared when frames were sent |
| tx_irq | output | 1 | Sticky transmit-complete flag |

## Verification
Each memory request is answered by the model one cycle after it is raised, and the engine moves on in the cycle that follows the acknowledge. The bench therefore does not predict memory timing; it checks descriptor contents only after `done`. A frame byte counts as transferred only in a cycle where `out_valid` and `out_ready` are both high at the sampling point before the clock edge. A byte seen stalled must still be on the output one cycle later. `tx_irq` and `dma_run` change on the edge that leaves the `done` cycle, so the bench checks them one cycle after it sees `done`. Length sweeps, multi-segment rings, ownership gaps and the 2048-byte boundary each compare the streamed bytes with values computed from the buffer addresses.

// File: rtl/tx_gather.sv
module tx_gather #(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2048,
  parameter int LENW      = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] list_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_last,
  output logic          busy,
  output logic          done,
  output logic          dma_run,
  output logic          tx_irq
);
  localparam int FW = $clog2(MAX_FRAME + 1);
  localparam int IW = $clog2(MAX_FRAME);
  localparam int CW = LENW - 2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_COPY, S_WB, S_SEND, S_NEXT, S_FIN} st_t;
  st_t state;

  logic [AW-1:0]   cur, head, d_buf, d_next;
  logic [31:0]     d_stat, d_ctl;
  logic [1:0]      widx;
  logic [CW-1:0]   cw;
  logic [FW-1:0]   acc;
  logic [IW-1:0]   ocnt;
  logic            searching, sent, err;
  logic [7:0]      fbuf [MAX_FRAME];

  logic [LENW-1:0] seg_len;
  logic            is_last;
  logic [FW:0]     sum;
  logic            overflow;
  logic [LENW:0]   off_nxt;
  logic [IW-1:0]   bidx [4];
  logic            ben  [4];

  assign seg_len  = d_ctl[LENW-1:0];
  assign is_last  = d_ctl[30];
  assign sum      = {1'b0, acc} + {{(FW+1-LENW){1'b0}}, seg_len};
  assign overflow = sum > (FW+1)'(MAX_FRAME);
  assign off_nxt  = {({1'b0, cw} + 1'b1), 2'b00};

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [LENW:0] off;
    assign off     = {1'b0, cw, 2'b00} + (LENW+1)'(k);
    assign ben[k]  = off < {1'b0, seg_len};
    assign bidx[k] = IW'(acc + FW'(off));
  end

  assign busy      = state != S_IDLE;
  assign done      = state == S_FIN;
  assign mem_req   = state inside {S_FETCH, S_COPY, S_WB};
  assign mem_we    = state == S_WB;
  assign mem_wdata = d_stat;
  assign out_valid = state == S_SEND;
  assign out_data  = fbuf[ocnt];
  assign out_last  = out_valid && (FW'(ocnt) + 1'b1 == acc);

  always_comb begin
    unique case (state)
      S_FETCH: mem_addr = cur + AW'({widx, 2'b00});
      S_COPY:  mem_addr = d_buf + AW'({cw, 2'b00});
      default: mem_addr = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (state == S_COPY && mem_ack)
      for (int k = 0; k < 4; k++)
        if (ben[k]) fbuf[bidx[k]] <= mem_rdata[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  cur <= '0;     head <= '0;   d_buf <= '0;  d_next <= '0;
      d_stat <= '0;     d_ctl <= '0;   widx <= '0;   cw <= '0;     acc <= '0;
      ocnt <= '0;       searching <= 1'b0; sent <= 1'b0; err <= 1'b0;
      dma_run <= 1'b0;  tx_irq <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          head <= list_base;  cur <= list_base;  widx <= '0;  acc <= '0;
          searching <= 1'b1;  sent <= 1'b0;  err <= 1'b0;
          dma_run <= 1'b1;    tx_irq <= 1'b0;
          state <= (list_base == '0) ? S_FIN : S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          widx <= widx + 1'b1;
          unique case (widx)
            2'd0: d_stat <= mem_rdata;
            2'd1: d_ctl  <= mem_rdata;
            2'd2: d_buf  <= AW'(mem_rdata);
            default: begin
              d_next <= AW'(mem_rdata);
              if (!d_stat[31]) begin
                if (searching && AW'(mem_rdata) != head && mem_rdata != '0) cur <= AW'(mem_rdata);
                else state <= S_FIN;
              end else begin
                searching <= 1'b0;
                if (overflow) begin
                  d_stat[14] <= 1'b1;  err <= 1'b1;  state <= S_WB;
                end else if (seg_len == '0) begin
                  d_stat[31] <= 1'b0;  state <= S_WB;
                end else begin
                  cw <= '0;  state <= S_COPY;
                end
              end
            end
          endcase
        end
        S_COPY: if (mem_ack) begin
          if (off_nxt >= {1'b0, seg_len}) begin
            d_stat[31] <= 1'b0;  state <= S_WB;
          end else cw <= cw + 1'b1;
        end
        S_WB: if (mem_ack) begin
          if (err) state <= S_FIN;
          else begin
            acc <= FW'(sum);
            if (is_last) begin
              ocnt <= '0;
              if (sum == '0) begin sent <= 1'b1; acc <= '0; state <= S_NEXT; end
              else state <= S_SEND;
            end else state <= S_NEXT;
          end
        end
        S_SEND: if (out_ready) begin
          if (out_last) begin sent <= 1'b1; acc <= '0; state <= S_NEXT; end
          else ocnt <= ocnt + 1'b1;
        end
        S_NEXT: begin
          if (d_next == '0) state <= S_FIN;
          else begin cur <= d_next; widx <= '0; state <= S_FETCH; end
        end
        default: begin
          if (sent) begin tx_irq <= 1'b1; dma_run <= 1'b0; end
          state <= S_IDLE;
        end
      endcase
    end
  end

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  a_r6_wb_release: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !err |-> !mem_wdata[31]);
  a_r7_wb_lenerr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && err |-> mem_wdata[14] && mem_wdata[31]);
  a_r7_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> acc <= FW'(MAX_FRAME));
  a_r8_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> $past(done));
  a_r8_run_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_run) |-> tx_irq);
endmodule

// File: tb/sim_tx_gather.sv
module sim_tx_gather;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [31:0] list_base = '0;
  logic        mem_req, mem_we, out_valid, out_last, busy, done, dma_run, tx_irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [7:0]  out_data;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tb_we = 1'b0;
  logic [31:0] tb_addr = '0, tb_data = '0;
  logic [31:0] mem [256];

  int nchk = 0, nfail = 0;
  logic [7:0] got[$];
  int lasts[$];
  logic [7:0] lf = 8'h5b;

  tx_gather u0 (.clk, .rst_n, .start, .list_base, .mem_req, .mem_we, .mem_addr, .mem_wdata,
                .mem_ack, .mem_rdata, .out_data, .out_valid, .out_ready, .out_last,
                .busy, .done, .dma_run, .tx_irq);

  function automatic logic [7:0] mb(input int a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {mb(int'(a) + 3), mb(int'(a) + 2), mb(int'(a) + 1), mb(int'(a))};
  endfunction

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr[9:2]] <= tb_data;
    if (mem_req && !mem_ack) begin
      if (mem_we && mem_addr < 32'h400) mem[mem_addr[9:2]] <= mem_wdata;
      mem_rdata <= (mem_addr >= 32'h400) ? pat({mem_addr[31:2], 2'b00}) : mem[mem_addr[9:2]];
      mem_ack <= 1'b1;
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] c,
                      input logic [31:0] b, input logic [31:0] n);
    poke(a, s); poke(a + 4, c); poke(a + 8, b); poke(a + 12, n);
  endtask

  task automatic run(input logic [31:0] base, input bit full);
    int cyc = 0;
    bit stall = 1'b0;
    logic [7:0] sdata = '0;
    got.delete(); lasts.delete();
    list_base = base;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (1) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = full ? 1'b1 : (lf[0] | lf[3]);
      if (stall) chk("R10 stalled byte held", {23'd0, out_valid, out_data}, {23'd0, 1'b1, sdata});
      if (out_valid && out_ready) begin
        got.push_back(out_data);
        if (out_last) lasts.push_back(got.size() - 1);
      end
      stall = out_valid && !out_ready;
      sdata = out_data;
      if (done) break;
      cyc++;
      if (cyc > 30000) begin
        nfail++; nchk++;
        $display("FAIL watchdog actual=%0d expected<=30000", cyc);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic chk_seg(input string tag, input int off, input int a, input int n);
    for (int k = 0; k < n; k++)
      chk(tag, (off + k < got.size()) ? {24'd0, got[off + k]} : 32'hdead_beef, {24'd0, mb(a + k)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mem_req", {31'd0, mem_req}, 0);
    chk("R1 reset out_valid", {31'd0, out_valid}, 0);
    chk("R1 reset flags", {28'd0, tx_irq, dma_run, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R5 R6 R8: single-segment sweep over lengths
    for (int len = 1; len <= 12; len++) begin
      desc(32'h100, 32'h8000_0000, 32'h4000_0000 | len, 32'h400 + len * 16, 32'h100);
      run(32'h100, len[0]);
      chk("R5 frame size", got.size(), len);
      chk_seg("R2 segment bytes", 0, 32'h400 + len * 16, len);
      chk("R5 last position", lasts.size() == 1 ? lasts[0] : -1, len - 1);
      chk("R6 status released", mem[8'h40], 32'h0);
      chk("R8 irq/run", {30'd0, tx_irq, dma_run}, 2'b10);
    end

    // R5 R6: two frames across three descriptors
    desc(32'h100, 32'h8000_0003, 32'h0000_0005, 32'h500, 32'h110);
    desc(32'h110, 32'h8000_0000, 32'h4000_0007, 32'h600, 32'h120);
    desc(32'h120, 32'h8000_0000, 32'h4000_0003, 32'h700, 32'h100);
    run(32'h100, 1'b0);
    chk("R5 total bytes", got.size(), 15);
    chk_seg("R5 seg A", 0, 32'h500, 5);
    chk_seg("R5 seg B", 5, 32'h600, 7);
    chk_seg("R5 seg C", 12, 32'h700, 3);
    chk("R5 last count", lasts.size(), 2);
    chk("R5 first last", lasts.size() > 0 ? lasts[0] : -1, 11);
    chk("R5 second last", lasts.size() > 1 ? lasts[1] : -1, 14);
    chk("R6 other bits kept", mem[8'h40], 32'h3);
    chk("R6 seg B released", mem[8'h44], 32'h0);
    chk("R6 seg C released", mem[8'h48], 32'h0);
    chk("R8 irq/run", {30'd0, tx_irq, dma_run}, 2'b10);

    // R3: skip a non-owned head
    desc(32'h140, 32'h0000_0000, 32'h4000_0004, 32'h780, 32'h150);
    desc(32'h150, 32'h8000_0000, 32'h4000_0004, 32'h800, 32'h140);
    run(32'h140, 1'b1);
    chk("R3 frame after skip", got.size(), 4);
    chk_seg("R3 bytes", 0, 32'h800, 4);
    chk("R3 head untouched", mem[8'h50], 32'h0);

    // R3 R8: nothing owned in the ring
    desc(32'h150, 32'h0000_0000, 32'h4000_0004, 32'h800, 32'h140);
    run(32'h140, 1'b1);
    chk("R3 nothing sent", got.size(), 0);
    chk("R3 R8 irq cleared, run kept", {30'd0, tx_irq, dma_run}, 2'b01);

    // R4: a gap in ownership ends the walk
    desc(32'h200, 32'h8000_0000, 32'h4000_0004, 32'h880, 32'h210);
    desc(32'h210, 32'h0000_0000, 32'h4000_0004, 32'h880, 32'h220);
    desc(32'h220, 32'h8000_0000, 32'h4000_0004, 32'h900, 32'h200);
    run(32'h200, 1'b0);
    chk("R4 one frame", got.size(), 4);
    chk_seg("R4 bytes", 0, 32'h880, 4);
    chk("R4 later descriptor still owned", mem[8'h88], 32'h8000_0000);

    // R9: zero next pointer ends the walk
    desc(32'h240, 32'h8000_0000, 32'h0000_0004, 32'h880, 32'h0);
    run(32'h240, 1'b1);
    chk("R9 no frame", got.size(), 0);
    chk("R9 written back", mem[8'h90], 32'h0);
    chk("R9 irq/run", {30'd0, tx_irq, dma_run}, 2'b01);

    // R7: one byte over the limit
    desc(32'h280, 32'h8000_0000, 32'h0000_0000 | 1500, 32'h400, 32'h290);
    desc(32'h290, 32'h8000_0000, 32'h4000_0000 | 549, 32'hA00, 32'h2A0);
    desc(32'h2A0, 32'h0000_0000, 32'h4000_0004, 32'h880, 32'h280);
    run(32'h280, 1'b1);
    chk("R7 nothing sent", got.size(), 0);
    chk("R7 length error flagged", mem[8'hA4], 32'h8000_4000);
    chk("R7 first segment released", mem[8'hA0], 32'h0);
    chk("R7 irq/run", {30'd0, tx_irq, dma_run}, 2'b01);

    // R7: exactly at the limit
    poke(32'h280, 32'h8000_0000);
    desc(32'h290, 32'h8000_0000, 32'h4000_0000 | 548, 32'hA00, 32'h2A0);
    run(32'h280, 1'b0);
    chk("R7 full frame size", got.size(), 2048);
    chk_seg("R7 first part", 0, 32'h400, 1500);
    chk_seg("R7 second part", 1500, 32'hA00, 548);
    chk("R7 last at end", lasts.size() == 1 ? lasts[0] : -1, 2047);
    chk("R8 irq/run", {30'd0, tx_irq, dma_run}, 2'b10);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule